// File: doc/BRIEF.md
# Clock-Generator Watchdog with Frequency Recovery

This block supervises a clock generator's control path. Software arms it by writing a 3-bit timeout code. From then on the block counts base periods derived from an external timebase tick. A prescaler turns the tick into a base period of one of two lengths, selected by a scale bit, and the code sets how many base periods make up the timeout. If software does not write the code again before the count runs out, the block raises a one-cycle system reset pulse and sets a sticky alarm flag.

At the same expiry the block can also move the active frequency selection to a safe value. That value is either the hardware strap setting or a stored 9-bit recovery code. Software picks the source with a select bit, and the action-select bit decides whether the frequency is touched at all. The selected recovery value stays in place until software writes a new frequency. Both prescaler lengths are parameters, so a testbench can make them short.

Top module: `clkgen_watchdog`

## Requirements
- R1: After synchronous reset `sys_reset_o` and `alarm_o` are 0, `freq_sel_o` equals `strap_freq_i`, and the timer code register holds 000, so no timeout occurs while no code is written.
- R2: One base period is `SHORT_TICKS` cycles with `tick_i` high when `scale_long_i` is 0, and `LONG_TICKS` such cycles when it is 1.
- R3: A write of code N (1 to 7) on `wd_wr_i` starts a timeout of N base periods. Counting begins with the first tick after the write cycle, and a tick in the write cycle itself is not counted.
- R4: Code 000 disables the countdown while `test_en_i` is 0. While `test_en_i` is 1, code 000 gives a timeout of one base period.
- R5: At expiry `sys_reset_o` is high for exactly one cycle. After that the countdown stays stopped, with no further pulse, until the next code write.
- R6: `alarm_o` goes to 1 at expiry and stays at 1. A write of a nonzero code leaves it unchanged, and only a write of code 000 clears it.
- R7: Any code write restarts both the prescaler and the countdown. A write in the cycle where the timeout would end wins: no pulse is given and a fresh timeout starts.
- R8: With `rst_only_i` = 0, expiry loads a recovery value into `freq_sel_o` in the same cycle that `sys_reset_o` rises. With `rst_only_i` = 1, `freq_sel_o` is left unchanged.
- R9: The recovery value is `strap_freq_i` when `rec_stored_i` is 0 and `rec_code_i` when it is 1.
- R10: A `sw_freq_wr_i` strobe loads `sw_freq_i` into `freq_sel_o` one cycle later. A recovery value holds until such a strobe. If the strobe falls in the same cycle as a recovering expiry, the recovery value wins.
- R11: The prescaler advances only in cycles with `tick_i` high, so gaps in the tick stretch the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase tick enable |
| scale_long_i | input | 1 | Base period select: 0 short, 1 long |
| wd_wr_i | input | 1 | Timer code write strobe |
| wd_code_i | input | 3 | Timer code written on strobe |
| test_en_i | input | 1 | Enables code 000 as a one-period test timeout |
| rst_only_i | input | 1 | 1: reset only; 0: reset and load recovery frequency |
| rec_stored_i | input | 1 | Recovery source: 0 strap, 1 stored code |
| rec_code_i | input | FREQ_W | Stored recovery frequency code |
| strap_freq_i | input | FREQ_W | Hardware strap frequency setting |
| sw_freq_wr_i | input | 1 | Software frequency write strobe |
| sw_freq_i | input | FREQ_W | Software frequency selection |
| freq_sel_o | output | FREQ_W | Active frequency selection |
| sys_reset_o | output | 1 | One-cycle reset pulse at expiry |
| alarm_o | output | 1 | Sticky timeout flag |

## Verification
The hardest situations to reach are the same-cycle collisions: a code write that lands exactly on the expiring tick, and a software frequency write that coincides with a recovering expiry. With `tick_i` held high, the timeout length in cycles is exact. The stimulus therefore counts clock edges from the write and places the second strobe on the predicted expiry edge. The tick-gap case feeds `tick_i` by hand, one pulse at a time, so that expiry lands on a known pulse.

// File: rtl/clkgen_wdt_pkg.sv
package clkgen_wdt_pkg;

  // Width of the watchdog timeout code.
  localparam int unsigned CODE_W = 3;

  // Action taken when the timeout expires.
  typedef enum logic {
    ACT_RESET_RECOVER = 1'b0,
    ACT_RESET_ONLY    = 1'b1
  } wdt_action_e;

  // Where the recovery frequency comes from.
  typedef enum logic {
    SRC_STRAP  = 1'b0,
    SRC_STORED = 1'b1
  } wdt_src_e;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned SHORT_TICKS = 294,
  parameter int unsigned LONG_TICKS  = 2340
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  input  logic long_i,
  output logic base_tick_o
);
  localparam int unsigned MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int unsigned PRE_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last_cnt;

  assign last_cnt    = long_i ? PRE_W'(LONG_TICKS - 1) : PRE_W'(SHORT_TICKS - 1);
  // The >= compare also covers a scale change part-way through a period.
  assign base_tick_o = run_i && !clear_i && tick_i && (pre_q >= last_cnt);

  always_ff @(posedge clk) begin
    if (rst || clear_i || !run_i) begin
      pre_q <= '0;
    end else if (tick_i) begin
      if (base_tick_o) pre_q <= '0;
      else             pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import clkgen_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              test_en_i,
  input  logic              base_tick_i,
  output logic              run_o,
  output logic              expire_o
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] remain_q;
  logic              armed_q;
  logic              code_zero;

  assign code_zero = (code_q == '0);
  assign run_o     = armed_q && (!code_zero || test_en_i);
  // A write in the same cycle wins over expiry.
  assign expire_o  = run_o && base_tick_i && !wr_i && (remain_q == CODE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      remain_q <= '0;
      armed_q  <= 1'b0;
    end else if (wr_i) begin
      code_q   <= code_i;
      remain_q <= (code_i == '0) ? CODE_W'(1) : code_i;
      armed_q  <= 1'b1;
    end else if (expire_o) begin
      armed_q  <= 1'b0;
    end else if (run_o && base_tick_i) begin
      remain_q <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_freq_mux.sv
module wdt_freq_mux
  import clkgen_wdt_pkg::*;
#(
  parameter int unsigned FREQ_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              expire_i,
  input  wdt_action_e       action_i,
  input  wdt_src_e          src_i,
  input  logic [FREQ_W-1:0] rec_code_i,
  input  logic [FREQ_W-1:0] strap_freq_i,
  input  logic              sw_wr_i,
  input  logic [FREQ_W-1:0] sw_freq_i,
  output logic [FREQ_W-1:0] freq_o
);
  logic [FREQ_W-1:0] recovery_val;

  assign recovery_val = (src_i == SRC_STORED) ? rec_code_i : strap_freq_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_o <= strap_freq_i;
    end else if (expire_i && (action_i == ACT_RESET_RECOVER)) begin
      freq_o <= recovery_val;
    end else if (sw_wr_i) begin
      freq_o <= sw_freq_i;
    end
  end
endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import clkgen_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              expire_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              sys_reset_o,
  output logic              alarm_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sys_reset_o <= 1'b0;
      alarm_o     <= 1'b0;
    end else begin
      sys_reset_o <= expire_i;
      if (wr_i && (code_i == '0)) alarm_o <= 1'b0;
      else if (expire_i)          alarm_o <= 1'b1;
    end
  end
endmodule

// File: rtl/clkgen_watchdog.sv
module clkgen_watchdog
  import clkgen_wdt_pkg::*;
#(
  parameter int unsigned FREQ_W      = 9,
  parameter int unsigned SHORT_TICKS = 294,
  parameter int unsigned LONG_TICKS  = 2340
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              scale_long_i,
  input  logic              wd_wr_i,
  input  logic [2:0]        wd_code_i,
  input  logic              test_en_i,
  input  logic              rst_only_i,
  input  logic              rec_stored_i,
  input  logic [FREQ_W-1:0] rec_code_i,
  input  logic [FREQ_W-1:0] strap_freq_i,
  input  logic              sw_freq_wr_i,
  input  logic [FREQ_W-1:0] sw_freq_i,
  output logic [FREQ_W-1:0] freq_sel_o,
  output logic              sys_reset_o,
  output logic              alarm_o
);
  logic base_tick;
  logic run;
  logic expire;

  wdt_prescaler #(
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS)
  ) u_pre (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (wd_wr_i),
    .run_i      (run),
    .tick_i     (tick_i),
    .long_i     (scale_long_i),
    .base_tick_o(base_tick)
  );

  wdt_countdown u_cnt (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (wd_wr_i),
    .code_i     (wd_code_i),
    .test_en_i  (test_en_i),
    .base_tick_i(base_tick),
    .run_o      (run),
    .expire_o   (expire)
  );

  wdt_status u_stat (
    .clk        (clk),
    .rst        (rst),
    .expire_i   (expire),
    .wr_i       (wd_wr_i),
    .code_i     (wd_code_i),
    .sys_reset_o(sys_reset_o),
    .alarm_o    (alarm_o)
  );

  wdt_freq_mux #(.FREQ_W(FREQ_W)) u_mux (
    .clk         (clk),
    .rst         (rst),
    .expire_i    (expire),
    .action_i    (wdt_action_e'(rst_only_i)),
    .src_i       (wdt_src_e'(rec_stored_i)),
    .rec_code_i  (rec_code_i),
    .strap_freq_i(strap_freq_i),
    .sw_wr_i     (sw_freq_wr_i),
    .sw_freq_i   (sw_freq_i),
    .freq_o      (freq_sel_o)
  );
endmodule

// File: rtl/clkgen_watchdog_chk.sv
module clkgen_watchdog_chk #(
  parameter int unsigned FREQ_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              wd_wr_i,
  input logic [2:0]        wd_code_i,
  input logic              rst_only_i,
  input logic              sw_freq_wr_i,
  input logic [FREQ_W-1:0] freq_sel_o,
  input logic              sys_reset_o,
  input logic              alarm_o
);
  // R5
  reset_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    sys_reset_o |=> !sys_reset_o);

  // R6
  alarm_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_o) |-> sys_reset_o);

  // R6
  alarm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm_o) |-> ($past(wd_wr_i) && ($past(wd_code_i) == 3'd0)));

  // R7
  write_blocks_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wd_wr_i) |-> !sys_reset_o);

  // R10
  freq_change_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(freq_sel_o) |-> ($past(sw_freq_wr_i) || (sys_reset_o && !$past(rst_only_i))));

  // R8
  reset_only_keeps_freq_chk: assert property (@(posedge clk) disable iff (rst)
    (sys_reset_o && $past(rst_only_i) && !$past(sw_freq_wr_i)) |-> $stable(freq_sel_o));
endmodule

bind clkgen_watchdog clkgen_watchdog_chk #(.FREQ_W(FREQ_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wd_wr_i     (wd_wr_i),
  .wd_code_i   (wd_code_i),
  .rst_only_i  (rst_only_i),
  .sw_freq_wr_i(sw_freq_wr_i),
  .freq_sel_o  (freq_sel_o),
  .sys_reset_o (sys_reset_o),
  .alarm_o     (alarm_o)
);

// File: tb/tb_clkgen_watchdog.sv
`timescale 1ns/1ps
module tb_clkgen_watchdog;
  localparam int FW = 9;
  localparam int SH = 4;
  localparam int LG = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b1, scale_long_i = 1'b0, wd_wr_i = 1'b0, test_en_i = 1'b0;
  logic [2:0] wd_code_i = 3'd0;
  logic rst_only_i = 1'b1, rec_stored_i = 1'b0, sw_freq_wr_i = 1'b0;
  logic [FW-1:0] rec_code_i = 9'h1A5, strap_freq_i = 9'h033, sw_freq_i = 9'h000;
  logic [FW-1:0] freq_sel_o;
  logic sys_reset_o, alarm_o;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  clkgen_watchdog #(.FREQ_W(FW), .SHORT_TICKS(SH), .LONG_TICKS(LG)) dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  // Ends at the negedge after the write edge.
  task automatic wd_write(logic [2:0] c);
    @(negedge clk); wd_code_i = c; wd_wr_i = 1'b1;
    @(posedge clk);
    @(negedge clk); wd_wr_i = 1'b0;
  endtask

  task automatic sw_write(logic [FW-1:0] v);
    @(negedge clk); sw_freq_i = v; sw_freq_wr_i = 1'b1;
    @(posedge clk);
    @(negedge clk); sw_freq_wr_i = 1'b0;
  endtask

  // Called just after a write; expects the pulse after edge n.
  task automatic expect_expiry(int n, string tag);
    repeat (n - 1) @(posedge clk);
    @(negedge clk); chk({tag, " no early pulse"}, sys_reset_o, 0);
    @(posedge clk);
    @(negedge clk); chk({tag, " pulse"}, sys_reset_o, 1);
    chk({tag, " alarm set"}, alarm_o, 1);
    @(posedge clk);
    @(negedge clk); chk({tag, " pulse width R5"}, sys_reset_o, 0);
  endtask

  task automatic quiet(int n, string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (sys_reset_o) seen++;
    end
    chk(tag, seen, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 sys_reset after reset", sys_reset_o, 0);
    chk("R1 alarm after reset", alarm_o, 0);
    chk("R1 freq is strap", freq_sel_o, 9'h033);
    quiet(40, "R1 no timeout while unarmed");
  endtask

  task automatic t_short();
    scale_long_i = 1'b0; rst_only_i = 1'b1;
    wd_write(3'd1);
    expect_expiry(SH, "R2 R3 short code1");
    chk("R8 reset-only keeps freq", freq_sel_o, 9'h033);
    quiet(30, "R5 halted after expiry");
    chk("R6 alarm sticky", alarm_o, 1);
  endtask

  task automatic t_long();
    scale_long_i = 1'b1;
    wd_write(3'd3);
    chk("R6 nonzero write keeps alarm", alarm_o, 1);
    expect_expiry(3 * LG, "R2 R3 long code3");
    wd_write(3'd0);
    chk("R6 code0 write clears alarm", alarm_o, 0);
    quiet(40, "R4 code0 idle without test");
    chk("R6 alarm stays clear", alarm_o, 0);
    scale_long_i = 1'b0;
  endtask

  task automatic t_code7();
    wd_write(3'd7);
    expect_expiry(7 * SH, "R3 code7");
  endtask

  task automatic t_test_mode();
    test_en_i = 1'b1;
    wd_write(3'd0);
    expect_expiry(SH, "R4 test mode");
    test_en_i = 1'b0;
  endtask

  task automatic t_rearm();
    wd_write(3'd2);
    repeat (6) @(posedge clk);
    wd_write(3'd2);
    expect_expiry(2 * SH, "R7 rewrite restarts");
    wd_write(3'd1);
    repeat (SH - 1) @(posedge clk);
    wd_write(3'd1);
    chk("R7 write on expiry edge wins", sys_reset_o, 0);
    expect_expiry(SH, "R7 fresh timeout");
  endtask

  task automatic t_recover();
    rst_only_i = 1'b0; rec_stored_i = 1'b0;
    sw_write(9'h0F0);
    chk("R10 sw write", freq_sel_o, 9'h0F0);
    wd_write(3'd1);
    expect_expiry(SH, "R8 recover");
    chk("R9 strap source", freq_sel_o, 9'h033);
    rec_stored_i = 1'b1;
    wd_write(3'd1);
    expect_expiry(SH, "R8 recover stored");
    chk("R9 stored source", freq_sel_o, 9'h1A5);
    repeat (10) @(negedge clk);
    chk("R10 recovery value holds", freq_sel_o, 9'h1A5);
    sw_write(9'h055);
    chk("R10 sw write after recovery", freq_sel_o, 9'h055);
    // collision: sw strobe on the expiry edge
    wd_write(3'd1);
    repeat (SH - 1) @(posedge clk);
    @(negedge clk); sw_freq_i = 9'h111; sw_freq_wr_i = 1'b1;
    @(posedge clk);
    @(negedge clk); sw_freq_wr_i = 1'b0;
    chk("R10 collision pulse", sys_reset_o, 1);
    chk("R10 recovery wins collision", freq_sel_o, 9'h1A5);
    rst_only_i = 1'b1;
  endtask

  task automatic t_tick_gap();
    @(negedge clk); tick_i = 1'b0;
    wd_write(3'd1);
    for (int k = 0; k < SH - 1; k++) begin
      @(negedge clk); tick_i = 1'b1;
      @(posedge clk);
      @(negedge clk); tick_i = 1'b0;
      chk("R11 no pulse before last tick", sys_reset_o, 0);
      repeat (2) @(posedge clk);
    end
    @(negedge clk); chk("R11 gap holds count", sys_reset_o, 0);
    tick_i = 1'b1;
    @(posedge clk);
    @(negedge clk); tick_i = 1'b0;
    chk("R11 pulse on last tick", sys_reset_o, 1);
    tick_i = 1'b1;
  endtask

  initial begin
    t_reset();
    t_short();
    t_long();
    t_code7();
    t_test_mode();
    t_rearm();
    t_recover();
    t_tick_gap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1-all actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule